// File: doc/BRIEF.md
# Single-Bit I/O Bus Master

This block is the master end of a bit-addressed I/O bus. A host hands it one request at a time: drive a one into an addressed output bit, drive a zero into it, or read an addressed input bit. The bus itself is narrow. It has a set of address lines, one data-out wire, one strobe wire that makes the addressed external latch capture the data-out level, and one shared data-in wire. An external selector places the addressed device's bit on the data-in wire.

A write request puts the address and level on the bus, waits a setup interval, and raises the strobe for one cycle. It then holds the bus for a further interval. A test request puts the address on the bus and waits for the selector to settle. It then copies the data-in wire into a condition flag. The flag keeps that value until the next test. The handshake is a ready/valid pair, and ready is low for the whole of an operation.

Top module: `bitbus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, req_ready is 1 and bus_strobe, bus_dout, bus_addr and cond_flag are all 0.
- R2: A request with req_op = 2'b01 (set one) is accepted at a clock edge where req_valid and req_ready are both 1. From that edge on, bus_addr equals req_addr and bus_dout is 1.
- R3: A request with req_op = 2'b00 (set zero) is accepted the same way. From the accepting edge on, bus_addr equals req_addr and bus_dout is 0.
- R4: For a write, bus_strobe is high for exactly one cycle, starting one cycle after the accepting edge. bus_addr and bus_dout are unchanged in the cycle before the strobe rises and in the cycle after it falls.
- R5: A request with req_op = 2'b10 (test) never pulses bus_strobe. It drives bus_addr from the accepting edge. cond_flag takes the bus_din level present just before the second clock edge after acceptance.
- R6: req_ready is low for three cycles after a write is accepted and for two cycles after a test is accepted. Requests presented while it is low are ignored: they cause no strobe and no bus change.
- R7: cond_flag changes only on a test. Write requests leave it unchanged.
- R8: A request with the reserved code req_op = 2'b11 is not accepted. req_ready stays 1, and the bus and the flag are unchanged.
- R9: A request that is held valid is accepted at the first edge where req_ready is 1 again, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_op | input | 2 | Operation code: 00 set zero, 01 set one, 10 test, 11 reserved |
| req_addr | input | ADDR_W (3) | Bit address of the request |
| bus_addr | output | ADDR_W (3) | Address lines to the external latch and selector |
| bus_dout | output | 1 | Level to be captured by the addressed latch |
| bus_strobe | output | 1 | One-cycle capture strobe for writes |
| bus_din | input | 1 | Shared input wire from the external selector |
| cond_flag | output | 1 | Result of the most recent test |

## Verification
Several properties are checked by assertions on every cycle. The strobe lasts exactly one cycle, and the address and level are steady around both of its edges. A test is never followed by a strobe, and the strobe stays low while the block is idle. The address lines do not move while ready is low, and the flag holds outside a sample. Other behaviour can only be shown by the bench scenarios. These cover the exact edge at which the input wire is sampled, which the bench shows by moving bus_din between the edges. They also cover the address and level each strobe carries, checked against a scoreboard. Finally, the scenarios show that reserved and busy-time requests produce no extra strobe, and that a held request starts on the first ready cycle.

// File: rtl/bitbus_pkg.sv
package bitbus_pkg;

    typedef enum logic [1:0] {
        OP_CLR  = 2'b00,
        OP_SET  = 2'b01,
        OP_TEST = 2'b10,
        OP_RSVD = 2'b11
    } bb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_SAMPLE
    } bb_state_e;

    typedef struct packed {
        logic accept;
        logic strobe;
        logic sample;
        logic busy;
    } bb_ctl_t;

    function automatic logic op_is_write(bb_op_e op);
        return (op == OP_SET) || (op == OP_CLR);
    endfunction

    function automatic logic op_level(bb_op_e op);
        return op == OP_SET;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bitbus_seq.sv
module bitbus_seq
    import bitbus_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int HOLD_CYC   = 1,
    parameter int SAMPLE_CYC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  bb_op_e  req_op,
    output bb_ctl_t ctl
);
    localparam int MAX_CYC = max3(SETUP_CYC, HOLD_CYC, SAMPLE_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    bb_state_e        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        ctl     = '0;
        ctl.busy = (state != ST_IDLE);
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (op_is_write(req_op)) begin
                        ctl.accept = 1'b1;
                        state_n    = ST_SETUP;
                        cnt_n      = CNT_W'(SETUP_CYC - 1);
                    end else if (req_op == OP_TEST) begin
                        ctl.accept = 1'b1;
                        state_n    = ST_SAMPLE;
                        cnt_n      = CNT_W'(SAMPLE_CYC - 1);
                    end
                end
            end
            ST_SETUP: begin
                if (cnt == '0) state_n = ST_STROBE;
                else           cnt_n   = cnt - 1'b1;
            end
            ST_STROBE: begin
                ctl.strobe = 1'b1;
                state_n    = ST_HOLD;
                cnt_n      = CNT_W'(HOLD_CYC - 1);
            end
            ST_HOLD: begin
                if (cnt == '0) state_n = ST_IDLE;
                else           cnt_n   = cnt - 1'b1;
            end
            ST_SAMPLE: begin
                if (cnt == '0) begin
                    ctl.sample = 1'b1;
                    state_n    = ST_IDLE;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // R4: strobe never lasts longer than one cycle
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.strobe |=> !ctl.strobe);

    // R5: a sample never coincides with a strobe
    p_sample_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.sample |-> !ctl.strobe);

endmodule

// File: rtl/bitbus_drive.sv
module bitbus_drive
    import bitbus_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  bb_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr <= '0;
            bus_dout <= 1'b0;
        end else if (accept) begin
            bus_addr <= addr;
            if (op_is_write(op)) bus_dout <= op_level(op);
        end
    end

    // R4: setup, address and level steady in the cycle before the strobe
    p_setup_stable_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> ($stable(bus_addr) && $stable(bus_dout)));

    // R4: hold, address and level steady in the cycle after the strobe
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe) |-> ($stable(bus_addr) && $stable(bus_dout)));

endmodule

// File: rtl/bitbus_flag.sv
module bitbus_flag (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic din,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (sample) flag <= din;
    end

    // R7: flag holds between samples
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(flag));

endmodule

// File: rtl/bitbus_master.sv
module bitbus_master
    import bitbus_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int SETUP_CYC  = 1,
    parameter int HOLD_CYC   = 1,
    parameter int SAMPLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dout,
    output logic              bus_strobe,
    input  logic              bus_din,
    output logic              cond_flag
);
    bb_op_e  op;
    bb_ctl_t ctl;

    assign op = bb_op_e'(req_op);

    bitbus_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .SAMPLE_CYC(SAMPLE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_op   (op),
        .ctl      (ctl)
    );

    bitbus_drive #(.ADDR_W(ADDR_W)) u_drive (
        .clk     (clk),
        .rst     (rst),
        .accept  (ctl.accept),
        .op      (op),
        .addr    (req_addr),
        .strobe  (ctl.strobe),
        .bus_addr(bus_addr),
        .bus_dout(bus_dout)
    );

    bitbus_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .sample(ctl.sample),
        .din   (bus_din),
        .flag  (cond_flag)
    );

    assign req_ready  = !ctl.busy;
    assign bus_strobe = ctl.strobe;

    // R5: an accepted test is followed by no strobe
    p_test_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && op == OP_TEST) |=> !bus_strobe ##1 !bus_strobe);

    // R6: no strobe while idle
    p_idle_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_strobe);

    // R6: the address lines are frozen while busy
    p_busy_addr_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(bus_addr));

    // R8: a reserved code is never accepted
    p_rsvd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (req_ready && op == OP_RSVD) |=> (req_ready && $stable(bus_addr) && $stable(bus_dout)));

endmodule

// File: tb/tb_bitbus_master.sv
module tb_bitbus_master;
    import bitbus_pkg::*;

    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_dout;
    logic          bus_strobe;
    logic          bus_din;
    logic          cond_flag;
    logic [7:0]    in_bits = 8'h00;

    typedef struct {
        int addr;
        bit level;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    assign bus_din = in_bits[bus_addr];

    bitbus_master dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_strobe(bus_strobe),
        .bus_din   (bus_din),
        .cond_flag (cond_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: each strobe is matched against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_strobe) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(bus_addr) == e.addr, "R2/R3 strobe address", int'(bus_addr), e.addr);
                chk(bus_dout == e.level, "R2/R3 strobe level", int'(bus_dout), int'(e.level));
            end
        end
    end

    task automatic issue(input logic [1:0] op, input int a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = AW'(a);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic do_write(input bit one, input int a);
        exp_t e;
        e.addr = a; e.level = one;
        exp_q.push_back(e);
        issue(one ? OP_SET : OP_CLR, a);
        @(negedge clk);
        chk(req_ready == 1'b0, "R6 busy after write accept", int'(req_ready), 0);
        chk(int'(bus_addr) == a, one ? "R2 address" : "R3 address", int'(bus_addr), a);
        chk(bus_dout == one, one ? "R2 level" : "R3 level", int'(bus_dout), int'(one));
        chk(bus_strobe == 1'b0, "R4 strobe low during setup", int'(bus_strobe), 0);
        @(negedge clk);
        chk(bus_strobe == 1'b1, "R4 strobe high", int'(bus_strobe), 1);
        @(negedge clk);
        chk(bus_strobe == 1'b0, "R4 strobe one cycle", int'(bus_strobe), 0);
        chk(int'(bus_addr) == a, "R4 address hold", int'(bus_addr), a);
        chk(req_ready == 1'b0, "R6 busy during hold", int'(req_ready), 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R6 ready after write", int'(req_ready), 1);
    endtask

    task automatic do_test(input int a, input bit v);
        in_bits[a] = v;
        issue(OP_TEST, a);
        @(negedge clk);
        chk(req_ready == 1'b0, "R6 busy after test accept", int'(req_ready), 0);
        chk(int'(bus_addr) == a, "R5 test address", int'(bus_addr), a);
        chk(bus_strobe == 1'b0, "R5 no strobe on test", int'(bus_strobe), 0);
        @(negedge clk);
        chk(bus_strobe == 1'b0, "R5 no strobe on test", int'(bus_strobe), 0);
        @(negedge clk);
        chk(cond_flag == v, "R5 flag value", int'(cond_flag), int'(v));
        chk(req_ready == 1'b1, "R6 ready after test", int'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_strobe == 1'b0, "R1 ready/strobe in reset", int'({req_ready, bus_strobe}), 2);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(bus_addr == '0 && bus_dout == 1'b0, "R1 bus idle", int'({bus_addr, bus_dout}), 0);
        chk(cond_flag == 1'b0, "R1 flag cleared", int'(cond_flag), 0);

        // R2, R3, R4: writes to varied addresses
        do_write(1'b1, 3);
        do_write(1'b0, 3);
        do_write(1'b1, 7);
        do_write(1'b0, 0);
        do_write(1'b1, 5);

        // R5: tests of both levels
        do_test(4, 1'b1);
        do_test(4, 1'b0);
        do_test(7, 1'b1);

        // R7: writes leave the flag alone
        do_write(1'b0, 2);
        do_write(1'b1, 6);
        chk(cond_flag == 1'b1, "R7 flag held over writes", int'(cond_flag), 1);
        do_test(1, 1'b0);
        do_write(1'b1, 1);
        chk(cond_flag == 1'b0, "R7 flag held over write", int'(cond_flag), 0);

        // R5: sampling edge, bus_din is only 1 just before the second edge
        in_bits[2] = 1'b0;
        issue(OP_TEST, 2);
        @(posedge clk);
        #1 in_bits[2] = 1'b1;
        @(posedge clk);
        #1 in_bits[2] = 1'b0;
        @(negedge clk);
        chk(cond_flag == 1'b1, "R5 sample edge", int'(cond_flag), 1);

        // R6: a request while busy is ignored
        begin
            exp_t e;
            e.addr = 2; e.level = 1'b1;
            exp_q.push_back(e);
        end
        issue(OP_SET, 2);
        req_valid = 1'b1;
        req_op    = OP_CLR;
        req_addr  = AW'(5);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(int'(bus_addr) == 2, "R6 busy request ignored (addr)", int'(bus_addr), 2);
        chk(bus_dout == 1'b1, "R6 busy request ignored (level)", int'(bus_dout), 1);

        // R8: reserved code is not accepted
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = OP_RSVD;
        req_addr  = AW'(6);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 reserved keeps ready", int'(req_ready), 1);
        chk(int'(bus_addr) == 2, "R8 reserved leaves bus", int'(bus_addr), 2);
        chk(bus_strobe == 1'b0, "R8 reserved no strobe", int'(bus_strobe), 0);
        chk(cond_flag == 1'b1, "R8 reserved leaves flag", int'(cond_flag), 1);

        // R9: held request starts on the first ready cycle
        begin
            exp_t e;
            e.addr = 4; e.level = 1'b1;
            exp_q.push_back(e);
            e.addr = 6; e.level = 1'b0;
            exp_q.push_back(e);
        end
        issue(OP_SET, 4);
        req_valid = 1'b1;
        req_op    = OP_CLR;
        req_addr  = AW'(6);
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && int'(bus_addr) == 4, "R9 ready again, old address", int'(bus_addr), 4);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        chk(int'(bus_addr) == 6, "R9 back-to-back accept", int'(bus_addr), 6);
        chk(req_ready == 1'b0, "R9 busy on second request", int'(req_ready), 0);
        repeat (4) @(negedge clk);

        chk(exp_q.size() == 0, "R6 every write strobed once", exp_q.size(), 0);
        summary();
    end

endmodule